// File: doc/BRIEF.md
# Link Residency and Payload Measurement Counter

This block measures one quantity at a time on a serial link and keeps the total in a 64-bit accumulator. The quantity is picked by a report code. It is either the number of clock cycles in which a chosen link power condition holds, or the number of payload strobes, where one strobe stands for 16 bytes, on one of four transmit or receive traffic streams. Software reaches the block through a small register port that has a write strobe, a byte address, write data and combinational read data. The result is read as two 32-bit halves.

A measurement starts when software changes the start bit from 0 to 1. That change clears the accumulator. The measurement then runs in one of two ways. In manual mode it lasts until software writes the start bit back to 0. In timed mode it lasts for a window picked by a duration code, and the block clears the start bit itself when the window ends. The window is timed by a microsecond prescaler, and the parameter `CYC_PER_US` sets how many clock cycles make one microsecond.

Control is a three-state machine:
- **IDLE** waits for a start.
- **MANUAL** and **TIMED** both accumulate.

The transitions are:
- **IDLE to MANUAL**: start is raised with a manual or reserved duration code.
- **IDLE to TIMED**: start is raised with a timed duration code.
- **MANUAL to IDLE**: start is written 0.
- **TIMED to IDLE**: the window expires, or start is written 0 (abort).

Top module: `link_dwell_counter`

## Requirements
- R1: After reset, every register reads 0 and no measurement is running.
- R2: The control register is at address 0x10. The report code is bits 31:24, the duration code is bits 15:8 and start is bit 0. These fields read back as written, and all other bits read 0.
- R3: Address 0x14 reads result bits 31:0 and address 0x18 reads result bits 63:32. Writes to these two addresses leave the result unchanged. Any other address reads 0.
- R4: A write that takes start from 0 to 1 clears the result and begins a measurement. Writing 1 while start is already 1 neither clears the result nor restarts the window.
- R5: Duration code 0x00, and every code not listed in R6, selects manual mode. The counter samples every clock edge from the edge after the starting write up to and including the edge of the write that sets start to 0. After that the result holds.
- R6: The timed duration codes and their window lengths are 0x01 = 1000 us, 0x02 = 10000 us, 0x03 = 100000 us, 0x04 = 1000000 us, 0x05 = 2000000 us, 0x06 = 4000000 us and 0xFF = 4 us. A timed window samples exactly (length × CYC_PER_US) clock edges.
- R7: When the window ends, counting stops and start reads 0. If software writes start to 0 during a timed window, the window is aborted and the result holds.
- R8: The residency report codes use link_state bits as follows:
  - 0x00 counts every cycle.
  - Codes 0x01 to 0x07 count cycles with link_state bit (code−1) set. The bits are: bit0 Tx L0s, bit1 Rx L0s, bit2 L0, bit3 L1, bit4 L1.1, bit5 L1.2, bit6 config/recovery.
  - 0x08 counts cycles with both bit0 and bit1 set.
  - 0x09 counts cycles with bit7 (L1 aux) set.
- R9: Report codes 0x20 to 0x23 add 1 on each sampled edge where pay_stb bit (code−0x20) is high. The bits are: bit0 Tx stream A, bit1 Rx stream A, bit2 Tx stream B, bit3 Rx stream B.
- R10: Any report code not listed in R8 or R9 counts nothing.
- R11: The window length is fixed when the measurement starts. Changing the duration field during a window does not change that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| link_state | input | 8 | Link power condition flags (see R8) |
| pay_stb | input | 4 | Payload strobes, one per 16 bytes (see R9) |

## Verification
The bench sweeps every listed report code, and several unlisted ones, against constant flag patterns, in both manual and 4 us timed windows. A design with a wrong code-to-flag mapping, or with an off-by-one in the sampled edge count, gives a result that differs from samples × hit. Two real timed windows (1 ms and 10 ms) check the prescaler and the self-clearing start bit; a design that misscales the window or leaves start set would be caught there. Further runs cover three cases:
- a manual abort of a timed window,
- a start write while start is already set, which must neither clear nor re-time the window,
- writes to the result addresses, which must be ignored.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MANUAL = 2'd1,
        ST_TIMED  = 2'd2
    } ldc_state_e;

    localparam int LNK_W  = 8;
    localparam int PAY_W  = 4;
    localparam int CODE_W = 8;
    localparam int US_W   = 32;

    localparam logic [7:0] ADDR_CTRL = 8'h10;
    localparam logic [7:0] ADDR_LO   = 8'h14;
    localparam logic [7:0] ADDR_HI   = 8'h18;

    localparam logic [CODE_W-1:0] RPT_PAY_BASE = 8'h20;

    // Window length in microseconds; 0 means manual mode
    function automatic logic [US_W-1:0] dur_to_us(input logic [CODE_W-1:0] code);
        case (code)
            8'h01:   dur_to_us = 32'd1000;
            8'h02:   dur_to_us = 32'd10000;
            8'h03:   dur_to_us = 32'd100000;
            8'h04:   dur_to_us = 32'd1000000;
            8'h05:   dur_to_us = 32'd2000000;
            8'h06:   dur_to_us = 32'd4000000;
            8'hFF:   dur_to_us = 32'd4;
            default: dur_to_us = 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/ldc_event_sel.sv
module ldc_event_sel
    import ldc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [LNK_W-1:0]  link_state,
    input  logic [PAY_W-1:0]  pay_stb,
    output logic              hit
);

    localparam logic [CODE_W-1:0] PAY_LAST = RPT_PAY_BASE + CODE_W'(PAY_W - 1);

    always_comb begin
        hit = 1'b0;
        if (code == 8'h00) begin
            hit = 1'b1;
        end else if (code <= 8'h07) begin
            hit = link_state[3'(code - 8'd1)];
        end else if (code == 8'h08) begin
            hit = link_state[0] & link_state[1];
        end else if (code == 8'h09) begin
            hit = link_state[7];
        end else if (code >= RPT_PAY_BASE && code <= PAY_LAST) begin
            hit = pay_stb[2'(code - RPT_PAY_BASE)];
        end
    end

endmodule

// File: rtl/ldc_window_timer.sv
module ldc_window_timer
    import ldc_pkg::*;
#(
    parameter int CYC_PER_US = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic [US_W-1:0] lim_us,
    output logic            expire
);

    localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;
    logic             tick;

    assign tick   = (pre_q == PRE_LAST);
    assign expire = run && tick && (us_q == lim_us - 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (restart) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                us_q  <= us_q + 32'd1;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST); // R6

    AST_US_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && lim_us != 0) |-> (us_q < lim_us)); // R6

endmodule

// File: rtl/link_dwell_counter.sv
module link_dwell_counter
    import ldc_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int REG_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [LNK_W-1:0] link_state,
    input  logic [PAY_W-1:0] pay_stb
);

    localparam int ACC_W = 2 * REG_W;

    ldc_state_e        st_q, st_d;
    logic [CODE_W-1:0] rpt_q, dur_q;
    logic              start_q;
    logic [US_W-1:0]   lim_q;
    logic [ACC_W-1:0]  acc_q;

    logic ctrl_wr, go, halt, hit, tmr_expire;
    logic count_en, timer_run;
    logic [US_W-1:0] new_lim;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign go      = ctrl_wr && reg_wdata[0] && !start_q;
    assign halt    = ctrl_wr && !reg_wdata[0];
    assign new_lim = dur_to_us(reg_wdata[15:8]);

    ldc_event_sel u_sel (
        .code       (rpt_q),
        .link_state (link_state),
        .pay_stb    (pay_stb),
        .hit        (hit)
    );

    ldc_window_timer #(.CYC_PER_US(CYC_PER_US)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (go),
        .run     (timer_run),
        .lim_us  (lim_q),
        .expire  (tmr_expire)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (go) st_d = (new_lim == '0) ? ST_MANUAL : ST_TIMED;
            ST_MANUAL: if (halt) st_d = ST_IDLE;
            ST_TIMED:  if (halt || tmr_expire) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Outputs of the state machine
    always_comb begin
        count_en  = 1'b0;
        timer_run = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_MANUAL: count_en = 1'b1;
            ST_TIMED: begin
                count_en  = 1'b1;
                timer_run = 1'b1;
            end
            default:   ;
        endcase
    end

    // Control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_q   <= '0;
            dur_q   <= '0;
            start_q <= 1'b0;
            lim_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                rpt_q   <= reg_wdata[31:24];
                dur_q   <= reg_wdata[15:8];
                start_q <= tmr_expire ? 1'b0 : reg_wdata[0];
            end else if (tmr_expire) begin
                start_q <= 1'b0;
            end
            if (go) lim_q <= new_lim;
        end
    end

    // Accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                acc_q <= '0;
        else if (go)               acc_q <= '0;
        else if (count_en && hit)  acc_q <= acc_q + ACC_W'(1);
    end

    // Register read
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {rpt_q, 8'h00, dur_q, 7'h00, start_q};
            ADDR_LO:   reg_rdata = acc_q[REG_W-1:0];
            ADDR_HI:   reg_rdata = acc_q[ACC_W-1:REG_W];
            default:   reg_rdata = '0;
        endcase
    end

    AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (acc_q == '0)); // R4

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !go) |=> $stable(acc_q)); // R5

    AST_RUN_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> start_q); // R5

    AST_END_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TIMED && tmr_expire) |=> (!start_q && st_q == ST_IDLE)); // R7

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !go) |=>
            (acc_q == $past(acc_q) || acc_q == $past(acc_q) + ACC_W'(1))); // R8

endmodule

// File: tb/link_dwell_counter_tb.sv
module link_dwell_counter_tb;

    localparam int CPU = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [7:0]  link_state = 8'h00;
    logic [3:0]  pay_stb = 4'h0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    link_dwell_counter #(.CYC_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_state(link_state), .pay_stb(pay_stb)
    );

    // Called at a negedge; the write lands on the next posedge; returns at the following negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input logic [7:0] rpt, input logic [7:0] dur, input logic st);
        return {rpt, 8'h00, dur, 7'h00, st};
    endfunction

    // Expected hit per requirement R8..R10
    function automatic int exp_hit(input logic [7:0] c, input logic [7:0] p);
        if (c == 8'h00) return 1;
        if (c >= 8'h01 && c <= 8'h07) return int'(p[c - 8'd1]);
        if (c == 8'h08) return int'(p[0] & p[1]);
        if (c == 8'h09) return int'(p[7]);
        if (c >= 8'h20 && c <= 8'h23) return int'(p[c - 8'h20]);
        return 0;
    endfunction

    task automatic read_result(output logic [63:0] r);
        logic [31:0] lo, hi;
        rd(8'h14, lo);
        rd(8'h18, hi);
        r = {hi, lo};
    endtask

    task automatic wait_done;
        logic [31:0] c;
        rd(8'h10, c);
        for (int k = 0; k < 30000 && c[0]; k++) begin
            @(negedge clk);
            rd(8'h10, c);
        end
    endtask

    initial begin
        repeat (140000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] r, r2;
        logic [7:0]  codes [18];
        logic [7:0]  pats  [11];

        codes = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
                  8'h20, 8'h21, 8'h22, 8'h23, 8'h0A, 8'h1F, 8'h24, 8'h80};
        pats  = '{8'h00, 8'hFF, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h03};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h10, v); chk(v, 0, "R1 ctrl after reset");
        rd(8'h14, v); chk(v, 0, "R1 low after reset");
        rd(8'h18, v); chk(v, 0, "R1 high after reset");

        // R2 field layout and readback
        wr(8'h10, 32'hA5C3_7E00);
        rd(8'h10, v); chk(v, 32'hA500_7E00, "R2 ctrl readback");
        wr(8'h10, 32'h0);

        // Sweep: report codes x patterns, alternate manual and 4 us timed windows
        for (int ci = 0; ci < 18; ci++) begin
            for (int pi = 0; pi < 11; pi++) begin
                int samples, h;
                string tag;
                link_state = pats[pi];
                pay_stb    = pats[pi][3:0];
                h = exp_hit(codes[ci], pats[pi]);
                if (codes[ci] <= 8'h09) tag = "R8";
                else if (codes[ci] >= 8'h20 && codes[ci] <= 8'h23) tag = "R9";
                else tag = "R10";
                if ((pi % 2) == 0) begin
                    int m;
                    logic [7:0] d;
                    m = 2 + (pi % 5);
                    d = (pi % 4 == 0) ? 8'h00 : 8'h07; // 0x07 reserved -> manual
                    wr(8'h10, ctl(codes[ci], d, 1'b1));
                    repeat (m) @(negedge clk);
                    wr(8'h10, ctl(codes[ci], d, 1'b0));
                    samples = m + 1;
                    read_result(r);
                    chk(r, 64'(samples * h), $sformatf("%s/R5 manual code=%0h pat=%0h", tag, codes[ci], pats[pi]));
                end else begin
                    wr(8'h10, ctl(codes[ci], 8'hFF, 1'b1));
                    wait_done();
                    samples = 4 * CPU;
                    read_result(r);
                    chk(r, 64'(samples * h), $sformatf("%s/R6 timed code=%0h pat=%0h", tag, codes[ci], pats[pi]));
                end
            end
        end
        link_state = 8'h00;
        pay_stb = 4'h0;

        // R5 result holds after manual stop
        wr(8'h10, ctl(8'h00, 8'h00, 1'b1));
        repeat (4) @(negedge clk);
        wr(8'h10, ctl(8'h00, 8'h00, 1'b0));
        read_result(r);
        repeat (6) @(negedge clk);
        read_result(r2);
        chk(r2, r, "R5 hold after stop");
        chk(r, 64'd5, "R5 manual every-cycle count");

        // R3 writes to result addresses ignored, unmapped reads 0
        wr(8'h14, 32'hDEAD_BEEF);
        wr(8'h18, 32'h1234_5678);
        read_result(r2);
        chk(r2, 64'd5, "R3 result writes ignored");
        rd(8'h1C, v); chk(v, 0, "R3 unmapped read");

        // R4 start clears previous result
        wr(8'h10, ctl(8'h80, 8'h00, 1'b1));
        repeat (2) @(negedge clk);
        wr(8'h10, ctl(8'h80, 8'h00, 1'b0));
        read_result(r);
        chk(r, 0, "R4 clear on start");

        // R6/R7 1 ms window: 1000 * CPU samples, start self-clears
        wr(8'h10, ctl(8'h00, 8'h01, 1'b1));
        wait_done();
        rd(8'h10, v); chk(v[0], 0, "R7 start cleared at window end");
        read_result(r); chk(r, 64'(1000 * CPU), "R6 1ms window length");
        repeat (5) @(negedge clk);
        read_result(r); chk(r, 64'(1000 * CPU), "R7 stopped after window");

        // R6 10 ms window
        wr(8'h10, ctl(8'h00, 8'h02, 1'b1));
        wait_done();
        read_result(r); chk(r, 64'(10000 * CPU), "R6 10ms window length");

        // R7 abort of timed window
        wr(8'h10, ctl(8'h00, 8'h01, 1'b1));
        repeat (9) @(negedge clk);
        wr(8'h10, ctl(8'h00, 8'h01, 1'b0));
        read_result(r); chk(r, 64'd10, "R7 abort count");
        repeat (5) @(negedge clk);
        read_result(r2); chk(r2, 64'd10, "R7 abort holds");

        // R11/R4 rewrite with start already set: no clear, window not re-timed
        wr(8'h10, ctl(8'h00, 8'hFF, 1'b1));
        repeat (2) @(negedge clk);
        wr(8'h10, ctl(8'h00, 8'h01, 1'b1));
        wait_done();
        read_result(r); chk(r, 64'(4 * CPU), "R11 duration latched at start");
        rd(8'h10, v); chk(v[0], 0, "R11 start cleared after original window");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule